// File: doc/BRIEF.md
# Trace Encoder Jump Target Cache

This block sits inside an instruction trace encoder and remembers recently seen uninferable jump targets. Each time the encoder meets an uninferable jump, it presents the target address. The block looks the address up in a small direct-mapped table. On a hit, the encoder can emit a short table index instead of a full or differential address. On a miss, the encoder must report the address itself, and the table entry at that index is overwritten with the new target.

A synchronization event clears every entry. The decoder keeps an identical table, so the block's behaviour has to be exactly predictable from the sequence of targets, sync events and the instruction-alignment setting. The alignment setting chooses which address bits form the index. When compressed instructions are allowed, the index starts at bit 1. When they are not, it starts at bit 2. Each result appears on the outputs one cycle after its strobe.

Top module: `jtc_cache`

## Requirements
- R1: While reset (rst_n low, sampled on the clock) is held, and after it is released, res_vld, res_hit, res_idx and res_addr are all zero and every entry is invalid.
- R2: res_vld is high in exactly the cycles that follow a cycle with tgt_vld high, and low otherwise.
- R3: The index of a target is addr[IDX_W:1] when cmp_en is 1, and addr[IDX_W+1:2] when cmp_en is 0. res_idx carries this index for every result.
- R4: A target equal to the valid entry at its index gives res_hit = 1 and res_addr = 0, and leaves the entry unchanged.
- R5: A target that does not match gives res_hit = 0 and res_addr equal to the target. The entry is overwritten, so the same target presented next hits.
- R6: A different target that maps to the same index evicts the earlier one, and the earlier target then misses.
- R7: An invalid entry never hits, even when its stored bits equal the target (for example, address zero straight after reset).
- R8: A sync pulse invalidates all entries, so a previously cached target misses afterwards.
- R9: A target presented in the same cycle as a sync is reported as a miss and is written into the cleared table, so it hits when presented next.
- R10: Targets on consecutive cycles see every write made by the one before. The same target presented twice in a row gives a miss, then a hit.
- R11: In a cycle after one without a strobe, res_hit, res_idx and res_addr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_vld | input | 1 | Uninferable jump target present this cycle |
| tgt_addr | input | ADDR_W | Jump target address |
| sync | input | 1 | Synchronization event: invalidate all entries |
| cmp_en | input | 1 | 1 = compressed instructions supported (index from bit 1) |
| res_vld | output | 1 | Lookup result valid (one cycle after tgt_vld) |
| res_hit | output | 1 | Target found in the table |
| res_idx | output | IDX_W | Table index of the target |
| res_addr | output | ADDR_W | Address to report on a miss; zero on a hit |

## Verification
The bench builds the block with ADDR_W = 16 and IDX_W = 2, giving four entries. With only four entries, index conflicts and evictions can be produced with short, hand-picked addresses. Both cmp_en settings are used on the same address, which shows the index moving between bit 1 and bit 2. The small table also makes it easy to check that a sync clears every entry, that a target arriving with a sync is still stored, and that a target repeated on the next cycle sees the write made by the first.

// File: rtl/jtc_pkg.sv
// Shared types for the jump target cache.
// Assumes: nothing beyond IEEE 1800-2017.
package jtc_pkg;

    // Instruction alignment that decides which address bits form the index.
    typedef enum logic [0:0] {
        ALIGN_WORD = 1'b0,   // no compressed instructions: index from bit 2
        ALIGN_HALF = 1'b1    // compressed instructions: index from bit 1
    } align_e;

endpackage

// File: rtl/jtc_index.sv
// Extracts the table index from a target address.
// Assumes ADDR_W >= IDX_W + 2, so that both bit windows exist.
module jtc_index
    import jtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  align_e              align,
    input  logic [ADDR_W-1:0]   addr,
    output logic [IDX_W-1:0]    idx
);

    // Select bits IDX_W:1 for halfword alignment, or IDX_W+1:2 otherwise.
    always_comb begin
        if (align == ALIGN_HALF) begin
            idx = addr[IDX_W:1];
        end else begin
            idx = addr[IDX_W+1:2];
        end
    end

endmodule

// File: rtl/jtc_store.sv
// Direct-mapped table of target addresses, each with a valid bit.
// It looks up combinationally, replaces an entry on a miss, and clears
// every entry on a flush. A lookup that arrives with a flush misses and
// is then written into the cleared table.
// Assumes the lookup index has already been derived from the address.
module jtc_store #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_vld,
    input  logic [IDX_W-1:0]    lk_idx,
    input  logic [ADDR_W-1:0]   lk_addr,
    input  logic                flush,
    output logic                lk_hit
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  valid;

    // Compare the target with the valid entry at its index; a flush forces a miss.
    always_comb begin
        lk_hit = !flush && valid[lk_idx] && (mem[lk_idx] == lk_addr);
    end

    // Flush clears the valid bits; a missing lookup fills its entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (flush) begin
                valid <= '0;
            end
            if (lk_vld && !lk_hit) begin
                valid[lk_idx] <= 1'b1;
                mem[lk_idx]   <= lk_addr;
            end
        end
    end

    // R5: after any lookup, its entry holds that target and is valid.
    p_entry_filled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_vld |=> (valid[$past(lk_idx)] && (mem[$past(lk_idx)] == $past(lk_addr))));

    // R8: a flush without a lookup leaves no valid entry.
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !lk_vld) |=> (valid == '0));

    // R9: a flush with a lookup leaves exactly that one entry valid.
    p_flush_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lk_vld) |=> ($countones(valid) == 1));

endmodule

// File: rtl/jtc_result.sv
// Output register for lookup results. It holds the last result between
// strobes and clears the address field on a hit.
// Assumes the hit and index inputs describe the target strobed this cycle.
module jtc_result #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic                in_hit,
    input  logic [IDX_W-1:0]    in_idx,
    input  logic [ADDR_W-1:0]   in_addr,
    output logic                res_vld,
    output logic                res_hit,
    output logic [IDX_W-1:0]    res_idx,
    output logic [ADDR_W-1:0]   res_addr
);

    // Capture the lookup on a strobe; otherwise hold the fields and drop valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_hit  <= 1'b0;
            res_idx  <= '0;
            res_addr <= '0;
        end else begin
            res_vld <= in_vld;
            if (in_vld) begin
                res_hit  <= in_hit;
                res_idx  <= in_idx;
                res_addr <= in_hit ? '0 : in_addr;
            end
        end
    end

    // R4: a hit never reports an address.
    p_hit_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_hit) |-> (res_addr == '0));

    // R11: without a strobe, the result fields stay put.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(res_hit) && $stable(res_idx) && $stable(res_addr)));

endmodule

// File: rtl/jtc_cache.sv
// Top level of the jump target cache. It derives the index, looks the
// target up in the table and registers the result one cycle later.
// Assumes ADDR_W >= IDX_W + 2, and that sync is a single-cycle pulse per event.
module jtc_cache
    import jtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tgt_vld,
    input  logic [ADDR_W-1:0]   tgt_addr,
    input  logic                sync,
    input  logic                cmp_en,
    output logic                res_vld,
    output logic                res_hit,
    output logic [IDX_W-1:0]    res_idx,
    output logic [ADDR_W-1:0]   res_addr
);

    align_e           align;
    logic [IDX_W-1:0] idx;
    logic             hit;

    // Map the compressed-support flag onto the alignment type.
    always_comb begin
        align = cmp_en ? ALIGN_HALF : ALIGN_WORD;
    end

    jtc_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_index (
        .align (align),
        .addr  (tgt_addr),
        .idx   (idx)
    );

    jtc_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_vld  (tgt_vld),
        .lk_idx  (idx),
        .lk_addr (tgt_addr),
        .flush   (sync),
        .lk_hit  (hit)
    );

    jtc_result #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (tgt_vld),
        .in_hit   (hit),
        .in_idx   (idx),
        .in_addr  (tgt_addr),
        .res_vld  (res_vld),
        .res_hit  (res_hit),
        .res_idx  (res_idx),
        .res_addr (res_addr)
    );

    // R2: a result follows each strobe by exactly one cycle.
    p_result_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_vld == $past(tgt_vld)));

    // R9: a target that arrives with a sync reports a miss with its address.
    p_sync_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_vld && sync) |=> (res_vld && !res_hit && (res_addr == $past(tgt_addr))));

endmodule

// File: tb/jtc_cache_bench.sv
module jtc_cache_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tgt_vld = 1'b0;
    logic [AW-1:0] tgt_addr = '0;
    logic          sync = 1'b0;
    logic          cmp_en = 1'b1;
    logic          res_vld;
    logic          res_hit;
    logic [IW-1:0] res_idx;
    logic [AW-1:0] res_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtc_cache #(.ADDR_W(AW), .IDX_W(IW)) u_jtc_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_vld  (tgt_vld),
        .tgt_addr (tgt_addr),
        .sync     (sync),
        .cmp_en   (cmp_en),
        .res_vld  (res_vld),
        .res_hit  (res_hit),
        .res_idx  (res_idx),
        .res_addr (res_addr)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Compare the whole result against its expected value.
    task automatic check_res(string req, bit hit, logic [IW-1:0] idx, logic [AW-1:0] addr);
        check({req, " vld"}, 32'(res_vld), 32'd1);
        check({req, " hit"}, 32'(res_hit), 32'(hit));
        check({req, " idx"}, 32'(res_idx), 32'(idx));
        check({req, " addr"}, 32'(res_addr), 32'(addr));
    endtask

    // One strobe; the result is sampled at the following falling edge.
    task automatic send(logic [AW-1:0] a, bit s, bit c);
        @(negedge clk);
        tgt_vld = 1'b1; tgt_addr = a; sync = s; cmp_en = c;
        @(negedge clk);
        tgt_vld = 1'b0; sync = 1'b0;
    endtask

    task automatic pulse_sync();
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 vld", 32'(res_vld), 0);
        check("R1 hit", 32'(res_hit), 0);
        check("R1 idx", 32'(res_idx), 0);
        check("R1 addr", 32'(res_addr), 0);
        send(16'h0000, 0, 1);
        check_res("R7 zero after reset", 0, 2'd0, 16'h0000);
        send(16'h0000, 0, 1);
        check_res("R4 zero now cached", 1, 2'd0, 16'h0000);
    endtask

    task automatic t_fill_hit();
        pulse_sync();
        send(16'h1234, 0, 1);
        check_res("R5 miss", 0, 2'd2, 16'h1234);
        send(16'h1234, 0, 1);
        check_res("R4 hit", 1, 2'd2, 16'h0000);
    endtask

    task automatic t_conflict();
        send(16'h5674, 0, 1);
        check_res("R6 new tag", 0, 2'd2, 16'h5674);
        send(16'h1234, 0, 1);
        check_res("R6 evicted", 0, 2'd2, 16'h1234);
    endtask

    task automatic t_index();
        pulse_sync();
        send(16'h00A8, 0, 0);
        check_res("R3 word index", 0, 2'd2, 16'h00A8);
        send(16'h00A8, 0, 1);
        check_res("R3 half index", 0, 2'd0, 16'h00A8);
    endtask

    task automatic t_sync();
        send(16'h2222, 0, 1);
        send(16'h2222, 0, 1);
        check_res("R8 cached", 1, 2'd1, 16'h0000);
        pulse_sync();
        send(16'h2222, 0, 1);
        check_res("R8 after sync", 0, 2'd1, 16'h2222);
    endtask

    task automatic t_sync_same();
        send(16'h3330, 0, 1);
        send(16'h3330, 0, 1);
        send(16'h3330, 1, 1);
        check_res("R9 with sync", 0, 2'd0, 16'h3330);
        send(16'h3330, 0, 1);
        check_res("R9 kept", 1, 2'd0, 16'h0000);
    endtask

    task automatic t_back2back();
        pulse_sync();
        @(negedge clk);
        tgt_vld = 1'b1; tgt_addr = 16'h4446; cmp_en = 1'b1;
        @(negedge clk);
        check_res("R10 first", 0, 2'd3, 16'h4446);
        @(negedge clk);
        tgt_vld = 1'b0;
        check_res("R10 second", 1, 2'd3, 16'h0000);
        @(negedge clk);
        check("R2 idle vld", 32'(res_vld), 0);
        check("R11 hit held", 32'(res_hit), 1);
        check("R11 idx held", 32'(res_idx), 3);
        check("R11 addr held", 32'(res_addr), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_pre: begin
            check("R1 in reset vld", 32'(res_vld), 0);
        end
        rst_n = 1'b1;
        t_reset();
        t_fill_hit();
        t_conflict();
        t_index();
        t_sync();
        t_sync_same();
        t_back2back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule